// File: doc/BRIEF.md
# Out-of-Order Store Queue

This block holds stores from an out-of-order core between dispatch and the data cache. Stores enter in program order, each with a sequence number, and get a slot in a circular buffer. The retire logic reports the youngest retired sequence number. The queue then marks the matching older stores as allowed to write. A separate writeback pointer sends those stores to the data cache in order, through a request port with valid/ready handshaking. The cache may refuse a request; the queue then waits for a retry pulse before it offers the request again.

Stores leave the queue from the oldest end once the cache reports them complete. When several stores complete out of order, the whole run of completed entries at the oldest end is freed together. A squash from the pipeline removes stores younger than a given sequence number from the young end. It never removes a store that has already been allowed to write. A store-conditional is allowed to write as soon as it executes, before it retires. The buffer has one spare slot, so a full queue and an empty queue have different pointer states.

Top module: `stq_ring`

## Requirements
- R1: `ins_ready` is high only when fewer than DEPTH stores are held and no squash is presented. An accepted store takes the slot shown on `ins_slot`, and `occ_count` rises by one.
- R2: A retire report with sequence C walks from the oldest held store and marks each unmarked store whose sequence is no greater than C. The walk stops at the first unmarked store that is younger than C. Unmarked stores are never written to the cache.
- R3: Cache writes leave in program order, at most one per cycle, and only for marked stores. `wb_pending` counts marked stores that have not completed.
- R4: A marked store with size 0 completes without any cache request and is freed like a written store.
- R5: When the cache refuses a request, `dc_req_valid` falls in the next cycle and stays low, even if `dc_req_ready` rises, until a `dc_retry` pulse. In the cycle after the pulse, the same store is offered again until it is accepted.
- R6: A completion on `cpl_valid`/`cpl_slot` marks that store complete. Stores are freed only from the oldest end, and one cycle frees the whole run of consecutive completed stores. `occ_count` falls by the number freed.
- R7: A squash with sequence S removes, starting from the youngest, each store younger than S. It stops at the first store that is marked or is not younger than S. Removed stores are never written, and the next insert reuses the first removed slot.
- R8: A pulse on `sc_valid` for a held store-conditional (inserted with `ins_cond`=1) marks it at once, with no retire report, and it is then written.
- R9: In a cycle with a squash, an insert is not accepted and a retire report is ignored.
- R10: After reset the queue is empty: `occ_count`=0, `wb_pending`=0, `dc_req_valid`=0, `ins_ready`=1, `ins_slot`=0.
- R11: Slot numbers run from 0 to DEPTH and wrap from DEPTH back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Store offered for insertion |
| ins_ready | output | 1 | Insertion accepted this cycle |
| ins_seq | input | SEQ_W | Sequence number of the offered store |
| ins_addr | input | ADDR_W | Store address |
| ins_data | input | DATA_W | Store data |
| ins_size | input | SIZE_W | Access size in bytes, 0 = no data |
| ins_cond | input | 1 | Store is a store-conditional |
| ins_slot | output | IDX_W | Slot that the offered store takes |
| cmt_valid | input | 1 | Retire report valid |
| cmt_seq | input | SEQ_W | Youngest retired sequence number |
| sqsh_valid | input | 1 | Squash request |
| sqsh_seq | input | SEQ_W | Stores younger than this are removed |
| sc_valid | input | 1 | Store-conditional executed without fault |
| sc_slot | input | IDX_W | Slot of that store-conditional |
| dc_req_valid | output | 1 | Cache write request valid |
| dc_req_ready | input | 1 | Cache accepts the request |
| dc_req_addr | output | ADDR_W | Request address |
| dc_req_data | output | DATA_W | Request data |
| dc_req_size | output | SIZE_W | Request size |
| dc_req_slot | output | IDX_W | Slot of the requesting store |
| dc_retry | input | 1 | Cache can take a refused request again |
| cpl_valid | input | 1 | Cache write completed |
| cpl_slot | input | IDX_W | Slot of the completed store |
| occ_count | output | CNT_W | Number of stores held |
| wb_pending | output | CNT_W | Marked stores not yet complete |

## Verification
A pointer that drifts out of step with the stored entries shows up as a wrong `ins_slot` on the next insert, or as a jump in `occ_count` in the cycle after the squash or completion that caused it. A lost or duplicated mark shows up as a cache write that is missing, out of order, or from a removed store, or as `wb_pending` not returning to zero once traffic stops, within a few cycles of the retire report. Refusal handling is judged cycle by cycle on `dc_req_valid`: the request must fall one cycle after the refusal and must return exactly one cycle after the retry pulse.

// File: rtl/stq_pkg.sv
package stq_pkg;

   // State of the cache request port after a refusal.
   typedef enum logic [1:0] {
      WB_FREE  = 2'd0,   // offering requests normally
      WB_HELD  = 2'd1,   // refused, waiting for a retry pulse
      WB_ARMED = 2'd2    // retry seen, offering the held request again
   } wb_state_e;

endpackage

// File: rtl/stq_commit_scan.sv
module stq_commit_scan #(
   parameter int NSLOT = 5,
   parameter int IDX_W = 3,
   parameter int CNT_W = 3,
   parameter int SEQ_W = 16
) (
   input  logic                        en,
   input  logic [SEQ_W-1:0]            limit,
   input  logic [IDX_W-1:0]            head,
   input  logic [CNT_W-1:0]            cnt,
   input  logic [NSLOT-1:0]            flag,
   input  logic [NSLOT-1:0][SEQ_W-1:0] seq,
   output logic [NSLOT-1:0]            set_mask,
   output logic [CNT_W-1:0]            set_num
);

   // Walk oldest to youngest; stop at the first unmarked store younger than limit.
   always_comb begin
      logic stop;
      int   p;
      set_mask = '0;
      set_num  = '0;
      stop     = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         p = int'(head) + i;
         if (p >= NSLOT) p = p - NSLOT;
         if (en && !stop && (i < int'(cnt)) && !flag[p]) begin
            if (seq[p] > limit) begin
               stop = 1'b1;
            end else begin
               set_mask[p] = 1'b1;
               set_num     = set_num + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/stq_squash_scan.sv
module stq_squash_scan #(
   parameter int NSLOT = 5,
   parameter int IDX_W = 3,
   parameter int CNT_W = 3,
   parameter int SEQ_W = 16
) (
   input  logic                        en,
   input  logic [SEQ_W-1:0]            limit,
   input  logic [IDX_W-1:0]            tail,
   input  logic [CNT_W-1:0]            cnt,
   input  logic [NSLOT-1:0]            flag,
   input  logic [NSLOT-1:0][SEQ_W-1:0] seq,
   output logic [NSLOT-1:0]            kill_mask,
   output logic [CNT_W-1:0]            kill_num,
   output logic [IDX_W-1:0]            tail_new
);

   // Walk youngest to oldest; a marked store or a store not younger ends the walk.
   always_comb begin
      logic stop;
      int   p;
      kill_mask = '0;
      kill_num  = '0;
      tail_new  = tail;
      stop      = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         p = int'(tail) - 1 - i;
         if (p < 0) p = p + NSLOT;
         if (en && !stop && (i < int'(cnt))) begin
            if (flag[p] || (seq[p] <= limit)) begin
               stop = 1'b1;
            end else begin
               kill_mask[p] = 1'b1;
               kill_num     = kill_num + 1'b1;
               tail_new     = IDX_W'(p);
            end
         end
      end
   end

endmodule

// File: rtl/stq_wb_port.sv
module stq_wb_port
   import stq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cand,
   input  logic req_ready,
   input  logic retry,
   output logic req_valid,
   output logic fire
);

   wb_state_e st_q, st_d;

   assign req_valid = cand && (st_q != WB_HELD);
   assign fire      = req_valid && req_ready;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         WB_FREE:  if (req_valid && !req_ready) st_d = WB_HELD;
         WB_HELD:  if (retry) st_d = WB_ARMED;
         WB_ARMED: begin
            if (fire)                         st_d = WB_FREE;
            else if (req_valid && !req_ready) st_d = WB_HELD;
         end
         default:  st_d = WB_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= WB_FREE;
      else        st_q <= st_d;
   end

   // R5
   refuse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> !req_valid)
      else $error("request stayed up after a refusal");

   // R5
   retry_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WB_HELD) && retry && cand |=> req_valid)
      else $error("held request not offered after retry");

endmodule

// File: rtl/stq_ring.sv
module stq_ring
   import stq_pkg::*;
#(
   parameter int DEPTH    = 4,
   parameter int SEQ_W    = 16,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int SIZE_W   = 4,
   parameter int FREE_RUN = 1,
   localparam int NSLOT   = DEPTH + 1,
   localparam int IDX_W   = $clog2(NSLOT),
   localparam int CNT_W   = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   output logic              ins_ready,
   input  logic [SEQ_W-1:0]  ins_seq,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [DATA_W-1:0] ins_data,
   input  logic [SIZE_W-1:0] ins_size,
   input  logic              ins_cond,
   output logic [IDX_W-1:0]  ins_slot,
   input  logic              cmt_valid,
   input  logic [SEQ_W-1:0]  cmt_seq,
   input  logic              sqsh_valid,
   input  logic [SEQ_W-1:0]  sqsh_seq,
   input  logic              sc_valid,
   input  logic [IDX_W-1:0]  sc_slot,
   output logic              dc_req_valid,
   input  logic              dc_req_ready,
   output logic [ADDR_W-1:0] dc_req_addr,
   output logic [DATA_W-1:0] dc_req_data,
   output logic [SIZE_W-1:0] dc_req_size,
   output logic [IDX_W-1:0]  dc_req_slot,
   input  logic              dc_retry,
   input  logic              cpl_valid,
   input  logic [IDX_W-1:0]  cpl_slot,
   output logic [CNT_W-1:0]  occ_count,
   output logic [CNT_W-1:0]  wb_pending
);

   // ---------------- elaboration checks ----------------
   if (DEPTH < 2) begin : g_chk_depth
      $error("stq_ring: DEPTH must be at least 2");
   end
   if (SEQ_W < 2) begin : g_chk_seq
      $error("stq_ring: SEQ_W must be at least 2");
   end
   if (SIZE_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_chk_w
      $error("stq_ring: widths must be positive");
   end

   // ---------------- storage ----------------
   logic [NSLOT-1:0][SEQ_W-1:0]  seq_q;
   logic [NSLOT-1:0][ADDR_W-1:0] addr_q;
   logic [NSLOT-1:0][DATA_W-1:0] data_q;
   logic [NSLOT-1:0][SIZE_W-1:0] size_q;
   logic [NSLOT-1:0]             cond_q;
   logic [NSLOT-1:0]             occ_q, flag_q, done_q, issued_q;
   logic [IDX_W-1:0]             head_q, wb_q, tail_q;
   logic [CNT_W-1:0]             cnt_q, pend_q;

   function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
      return (v == IDX_W'(NSLOT - 1)) ? '0 : v + 1'b1;
   endfunction

   // ---------------- insert ----------------
   logic full, ins_fire;
   assign full      = (wrap_inc(tail_q) == head_q);
   assign ins_ready = !full && !sqsh_valid;
   assign ins_fire  = ins_valid && ins_ready;
   assign ins_slot  = tail_q;

   // ---------------- retire marking ----------------
   logic             cmt_en;
   logic [NSLOT-1:0] set_mask;
   logic [CNT_W-1:0] set_num;
   assign cmt_en = cmt_valid && !sqsh_valid;

   stq_commit_scan #(.NSLOT(NSLOT), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_cmt (
      .en(cmt_en), .limit(cmt_seq), .head(head_q), .cnt(cnt_q),
      .flag(flag_q), .seq(seq_q), .set_mask(set_mask), .set_num(set_num));

   // ---------------- squash ----------------
   logic [NSLOT-1:0] kill_mask;
   logic [CNT_W-1:0] kill_num;
   logic [IDX_W-1:0] tail_cut;

   stq_squash_scan #(.NSLOT(NSLOT), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_sq (
      .en(sqsh_valid), .limit(sqsh_seq), .tail(tail_q), .cnt(cnt_q),
      .flag(flag_q), .seq(seq_q), .kill_mask(kill_mask), .kill_num(kill_num),
      .tail_new(tail_cut));

   // ---------------- store-conditional early marking ----------------
   logic sc_hit;
   assign sc_hit = sc_valid && !sqsh_valid && occ_q[sc_slot] && cond_q[sc_slot]
                   && !flag_q[sc_slot] && !set_mask[sc_slot];

   // ---------------- writeback issue ----------------
   logic wb_open, wb_zero, wb_cand, wb_fire;
   assign wb_open = (wb_q != tail_q) && occ_q[wb_q] && flag_q[wb_q] && !done_q[wb_q]
                    && (pend_q != '0);
   assign wb_zero = wb_open && (size_q[wb_q] == '0);
   assign wb_cand = wb_open && (size_q[wb_q] != '0);

   stq_wb_port u_port (
      .clk(clk), .rst_n(rst_n), .cand(wb_cand), .req_ready(dc_req_ready),
      .retry(dc_retry), .req_valid(dc_req_valid), .fire(wb_fire));

   assign dc_req_addr = addr_q[wb_q];
   assign dc_req_data = data_q[wb_q];
   assign dc_req_size = size_q[wb_q];
   assign dc_req_slot = wb_q;

   // ---------------- completion ----------------
   logic             cpl_ok;
   logic [NSLOT-1:0] done_add, done_next;
   logic [CNT_W-1:0] done_num;
   assign cpl_ok = cpl_valid && occ_q[cpl_slot] && issued_q[cpl_slot] && !done_q[cpl_slot];

   always_comb begin
      done_add = '0;
      if (wb_zero) done_add[wb_q]    = 1'b1;
      if (cpl_ok)  done_add[cpl_slot] = 1'b1;
   end
   assign done_next = done_q | done_add;
   assign done_num  = CNT_W'(wb_zero) + CNT_W'(cpl_ok);

   // ---------------- freeing from the oldest end ----------------
   logic [NSLOT-1:0] free_mask;
   logic [CNT_W-1:0] free_num;
   logic [IDX_W-1:0] head_new;

   if (FREE_RUN != 0) begin : g_free_run
      always_comb begin
         logic stop;
         int   p;
         free_mask = '0;
         free_num  = '0;
         head_new  = head_q;
         stop      = 1'b0;
         for (int i = 0; i < NSLOT; i++) begin
            p = int'(head_q) + i;
            if (p >= NSLOT) p = p - NSLOT;
            if (!stop && (i < int'(cnt_q))) begin
               if (done_next[p]) begin
                  free_mask[p] = 1'b1;
                  free_num     = free_num + 1'b1;
                  head_new     = (p == NSLOT - 1) ? '0 : IDX_W'(p + 1);
               end else begin
                  stop = 1'b1;
               end
            end
         end
      end
   end else begin : g_free_one
      always_comb begin
         free_mask = '0;
         free_num  = '0;
         head_new  = head_q;
         if ((cnt_q != '0) && done_next[head_q]) begin
            free_mask[head_q] = 1'b1;
            free_num          = CNT_W'(1);
            head_new          = wrap_inc(head_q);
         end
      end
   end

   // ---------------- pointers and counters ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         wb_q   <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         pend_q <= '0;
      end else begin
         head_q <= head_new;
         if (wb_zero || wb_fire) wb_q <= wrap_inc(wb_q);
         if (sqsh_valid)    tail_q <= tail_cut;
         else if (ins_fire) tail_q <= wrap_inc(tail_q);
         cnt_q  <= cnt_q + CNT_W'(ins_fire) - free_num - kill_num;
         pend_q <= pend_q + set_num + CNT_W'(sc_hit) - done_num;
      end
   end

   // ---------------- per-slot status ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q    <= '0;
         flag_q   <= '0;
         done_q   <= '0;
         issued_q <= '0;
      end else begin
         for (int i = 0; i < NSLOT; i++) begin
            if (free_mask[i] || kill_mask[i]) begin
               occ_q[i]    <= 1'b0;
               flag_q[i]   <= 1'b0;
               done_q[i]   <= 1'b0;
               issued_q[i] <= 1'b0;
            end else if (ins_fire && (tail_q == IDX_W'(i))) begin
               occ_q[i]    <= 1'b1;
               flag_q[i]   <= 1'b0;
               done_q[i]   <= 1'b0;
               issued_q[i] <= 1'b0;
            end else begin
               if (set_mask[i] || (sc_hit && (sc_slot == IDX_W'(i)))) flag_q[i] <= 1'b1;
               if (done_add[i]) done_q[i] <= 1'b1;
               if (wb_fire && (wb_q == IDX_W'(i))) issued_q[i] <= 1'b1;
            end
         end
      end
   end

   // ---------------- payload ----------------
   always_ff @(posedge clk) begin
      if (ins_fire) begin
         seq_q[tail_q]  <= ins_seq;
         addr_q[tail_q] <= ins_addr;
         data_q[tail_q] <= ins_data;
         size_q[tail_q] <= ins_size;
         cond_q[tail_q] <= ins_cond;
      end
   end

   assign occ_count  = cnt_q;
   assign wb_pending = pend_q;

   // ---------------- assertions ----------------
   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && ins_ready |-> cnt_q < CNT_W'(DEPTH))
      else $error("insert accepted while full");

   // R6
   ring_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(tail_q) + NSLOT - int'(head_q)) % NSLOT) == int'(cnt_q))
      else $error("occupancy disagrees with pointer distance");

   // R3
   pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= cnt_q)
      else $error("pending count exceeds occupancy");

   // R3
   wb_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(wb_q) + NSLOT - int'(head_q)) % NSLOT) <= int'(cnt_q))
      else $error("writeback pointer outside the held range");

   // R6
   cpl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> occ_q[cpl_slot] && issued_q[cpl_slot] && !done_q[cpl_slot])
      else $error("completion for a store that was not written");

   // R5
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dc_req_valid && !dc_req_ready |=> $stable(dc_req_slot))
      else $error("refused request moved to another slot");

endmodule

// File: tb/stq_ring_tb.sv
`timescale 1ns/1ps
module stq_ring_tb;

   localparam int DEPTH  = 4;
   localparam int IDX_W  = 3;
   localparam int CNT_W  = 3;
   localparam int NVEC   = 9;

   // Row: [27:24] op (1 insert, 2 squash), [23:16] seq, [15:12] size,
   //      [11:8] expected slot (F = insert refused), [7:4] expected occupancy
   localparam logic [31:0] VEC [NVEC] = '{
      32'h010A4010, 32'h010B4120, 32'h010C4230, 32'h020A0110,
      32'h010D4120, 32'h010E4230, 32'h010F4340, 32'h01104F40,
      32'h01114F40 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              ins_valid = 0, ins_cond = 0, ins_ready;
   logic [15:0]       ins_seq = 0, ins_addr = 0;
   logic [31:0]       ins_data = 0;
   logic [3:0]        ins_size = 0;
   logic [IDX_W-1:0]  ins_slot;
   logic              cmt_valid = 0, sqsh_valid = 0, sc_valid = 0;
   logic [15:0]       cmt_seq = 0, sqsh_seq = 0;
   logic [IDX_W-1:0]  sc_slot = 0;
   logic              dc_req_valid, dc_req_ready = 1, dc_retry = 0;
   logic [15:0]       dc_req_addr;
   logic [31:0]       dc_req_data;
   logic [3:0]        dc_req_size;
   logic [IDX_W-1:0]  dc_req_slot;
   logic              cpl_valid = 0;
   logic [IDX_W-1:0]  cpl_slot = 0;
   logic [CNT_W-1:0]  occ_count, wb_pending;

   stq_ring #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_seq(ins_seq),
      .ins_addr(ins_addr), .ins_data(ins_data), .ins_size(ins_size),
      .ins_cond(ins_cond), .ins_slot(ins_slot),
      .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
      .sqsh_valid(sqsh_valid), .sqsh_seq(sqsh_seq),
      .sc_valid(sc_valid), .sc_slot(sc_slot),
      .dc_req_valid(dc_req_valid), .dc_req_ready(dc_req_ready),
      .dc_req_addr(dc_req_addr), .dc_req_data(dc_req_data),
      .dc_req_size(dc_req_size), .dc_req_slot(dc_req_slot),
      .dc_retry(dc_retry), .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
      .occ_count(occ_count), .wb_pending(wb_pending));

   int nchk = 0, nfail = 0;
   int log_n = 0, exp_n = 0;
   logic [15:0] log_addr [64];
   logic [31:0] log_data [64];

   // cache model: log accepted writes, complete them one cycle later
   logic auto_cpl = 1, fired = 0, man_req = 0;
   logic [IDX_W-1:0] fired_slot = 0, man_slot = 0;

   always @(negedge clk) begin
      if (rst_n && dc_req_valid && dc_req_ready) begin
         if (log_n < 64) begin
            log_addr[log_n] = dc_req_addr;
            log_data[log_n] = dc_req_data;
         end
         log_n++;
         fired = 1;
         fired_slot = dc_req_slot;
      end
   end

   always @(posedge clk) begin
      #1;
      cpl_valid = auto_cpl ? fired : man_req;
      cpl_slot  = auto_cpl ? fired_slot : man_slot;
      fired = 0;
      man_req = 0;
   end

   function automatic logic [15:0] a_of(int s);
      return 16'(16'h1000 + s);
   endfunction
   function automatic logic [31:0] d_of(int s);
      return {a_of(s), ~a_of(s)};
   endfunction

   task automatic check(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wait_cyc(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic ins(int s, int size, bit cond, output bit rdy, output int slot);
      step();
      ins_valid = 1; ins_seq = 16'(s); ins_addr = a_of(s); ins_data = d_of(s);
      ins_size = 4'(size); ins_cond = cond;
      @(negedge clk);
      rdy = ins_ready; slot = int'(ins_slot);
      step();
      ins_valid = 0;
   endtask

   task automatic ins_chk(string tag, int s, int size, bit cond, int exp_slot);
      bit r; int sl;
      ins(s, size, cond, r, sl);
      check({tag, " ready"}, int'(r), 1);
      check({tag, " slot"}, sl, exp_slot);
   endtask

   task automatic commit(int s);
      step(); cmt_valid = 1; cmt_seq = 16'(s);
      step(); cmt_valid = 0;
   endtask

   task automatic squash(int s);
      step(); sqsh_valid = 1; sqsh_seq = 16'(s);
      step(); sqsh_valid = 0;
   endtask

   task automatic man_cpl(int s);
      @(negedge clk); man_req = 1; man_slot = IDX_W'(s);
      @(posedge clk); #2;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic expect_write(string tag, int s);
      check({tag, " write addr"}, int'(log_addr[exp_n]), int'(a_of(s)));
      check({tag, " write data"}, int'(log_data[exp_n]), int'(d_of(s)));
      exp_n++;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      bit r; int sl;
      wait_cyc(3);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      check("R10 occ", int'(occ_count), 0);
      check("R10 pend", int'(wb_pending), 0);
      check("R10 req", int'(dc_req_valid), 0);
      check("R10 ready", int'(ins_ready), 1);
      check("R10 slot", int'(ins_slot), 0);

      // R1 R7 vector walk: inserts, a squash, then a full queue
      for (int r0 = 0; r0 < NVEC; r0++) begin
         int op, s, sz, es, ec;
         op = int'(VEC[r0][27:24]); s = int'(VEC[r0][23:16]);
         sz = int'(VEC[r0][15:12]); es = int'(VEC[r0][11:8]); ec = int'(VEC[r0][7:4]);
         if (op == 1) begin
            ins(s, sz, 0, r, sl);
            if (es == 15) check("R1 refused when full", int'(r), 0);
            else begin
               check("R1 accepted", int'(r), 1);
               check("R1 slot", sl, es);
            end
         end else begin
            squash(s);
            @(negedge clk);
            check("R7 tail after squash", int'(ins_slot), es);
         end
         @(negedge clk);
         check("R1 occupancy", int'(occ_count), ec);
      end

      // R2 R3: retire up to 13 marks 10 and 13 only
      commit(13);
      wait_cyc(10);
      @(negedge clk);
      check("R2 R3 write count", log_n, 2);
      expect_write("R3 first", 10);
      expect_write("R3 second", 13);
      check("R2 occ", int'(occ_count), 2);
      check("R2 pend", int'(wb_pending), 0);

      // R7: unmarked 14,15 removed, tail back to slot 2, never written
      squash(0);
      wait_cyc(3);
      @(negedge clk);
      check("R7 occ", int'(occ_count), 0);
      check("R7 slot reuse", int'(ins_slot), 2);
      check("R7 no write", log_n, 2);

      // R5: refusal and retry; R7 stop at marked store
      dc_req_ready = 0;
      ins_chk("R7 i20", 20, 4, 0, 2);
      ins_chk("R7 i21", 21, 4, 0, 3);
      ins_chk("R7 i22", 22, 4, 0, 4);
      commit(20);
      @(negedge clk);
      check("R5 offered", int'(dc_req_valid), 1);
      @(negedge clk);
      check("R5 dropped", int'(dc_req_valid), 0);
      squash(19);
      @(negedge clk);
      check("R7 stop at marked", int'(occ_count), 1);
      check("R7 tail", int'(ins_slot), 3);
      step(); dc_req_ready = 1;
      @(negedge clk);
      check("R5 still low", int'(dc_req_valid), 0);
      @(negedge clk);
      check("R5 still low 2", int'(dc_req_valid), 0);
      step(); dc_retry = 1;
      step(); dc_retry = 0;
      @(negedge clk);
      check("R5 resent", int'(dc_req_valid), 1);
      check("R5 same slot", int'(dc_req_slot), 2);
      wait_cyc(5);
      @(negedge clk);
      check("R5 written once", log_n, 3);
      expect_write("R5", 20);
      check("R5 occ", int'(occ_count), 0);

      // R4 R11: zero-size store and slot wrap
      ins_chk("R11 i30", 30, 4, 0, 3);
      ins_chk("R4 i31", 31, 0, 0, 4);
      ins_chk("R11 wrap", 32, 2, 0, 0);
      commit(32);
      wait_cyc(10);
      @(negedge clk);
      check("R4 write count", log_n, 5);
      expect_write("R4 before", 30);
      expect_write("R4 after", 32);
      check("R4 occ", int'(occ_count), 0);
      check("R4 pend", int'(wb_pending), 0);

      // R8: store-conditional marked by execution alone
      ins_chk("R8 i40", 40, 4, 1, 1);
      ins_chk("R8 i41", 41, 4, 0, 2);
      step(); sc_valid = 1; sc_slot = 3'd1;
      step(); sc_valid = 0;
      wait_cyc(6);
      @(negedge clk);
      check("R8 write count", log_n, 6);
      expect_write("R8", 40);
      check("R8 occ", int'(occ_count), 1);

      // R6: out-of-order completion frees a run at once
      squash(0);
      auto_cpl = 0;
      ins_chk("R6 i50", 50, 4, 0, 2);
      ins_chk("R6 i51", 51, 4, 0, 3);
      ins_chk("R6 i52", 52, 4, 0, 4);
      commit(52);
      wait_cyc(6);
      @(negedge clk);
      check("R6 writes", log_n, 9);
      expect_write("R6 a", 50);
      expect_write("R6 b", 51);
      expect_write("R6 c", 52);
      check("R6 pend", int'(wb_pending), 3);
      man_cpl(3);
      check("R6 not head occ", int'(occ_count), 3);
      check("R6 pend 2", int'(wb_pending), 2);
      man_cpl(4);
      check("R6 not head occ 2", int'(occ_count), 3);
      man_cpl(2);
      check("R6 run freed", int'(occ_count), 0);
      check("R6 pend 0", int'(wb_pending), 0);
      auto_cpl = 1;

      // R9: squash cycle blocks insert and drops retire report
      ins_chk("R9 i60", 60, 4, 0, 0);
      step();
      sqsh_valid = 1; sqsh_seq = 16'd100;
      cmt_valid = 1; cmt_seq = 16'd60;
      ins_valid = 1; ins_seq = 16'd61; ins_addr = a_of(61); ins_data = d_of(61);
      ins_size = 4'd4; ins_cond = 0;
      @(negedge clk);
      check("R9 ready low", int'(ins_ready), 0);
      step();
      sqsh_valid = 0; cmt_valid = 0; ins_valid = 0;
      wait_cyc(3);
      @(negedge clk);
      check("R9 occ", int'(occ_count), 1);
      check("R9 pend", int'(wb_pending), 0);
      check("R9 no write", log_n, 9);
      commit(60);
      wait_cyc(5);
      @(negedge clk);
      check("R9 later write", log_n, 10);
      expect_write("R9", 60);
      check("R9 occ end", int'(occ_count), 0);

      finish_run();
   end

endmodule